// File: doc/BRIEF.md
# Indexed-Byte I2C Target

This block is an I2C target that runs on a fast system clock and oversamples the open-drain SCL and SDA lines. Each line passes through a two-flop synchronizer and a three-sample agreement filter. Edge logic then finds SCL rising and falling edges and the START and STOP conditions. After a START the engine collects the address byte and compares its upper seven bits with a programmable 8-bit address. It also accepts an all-zero address byte as a general call. The low bit of a matching address byte picks the direction: master-read or master-write.

User logic is served one byte at a time, and every byte carries a byte index. The index returns to zero only when a master-write transfer is addressed. A master-read transfer continues from where the index last stood.

- On a read, the engine raises a request with the index. The user logic answers with the byte. The engine shifts it out MSB first and then samples the master's acknowledge bit.
- On a write, each received byte is shown for one system cycle together with its index. The user logic's accept level decides whether the engine acknowledges the byte or leaves it unacknowledged.

Both outputs are pull-low enables only. The engine never stretches the clock.

Top module: `i2c_indexed_target`

## Requirements
- R1: After reset, sda_pull, scl_pull, rd_req and wr_valid are 0 and byte_index is 0.
- R2: The address byte is received MSB first. Its bits 7:1 are compared with own_addr[7:1]. On a match, SDA is pulled low during the ninth (acknowledge) SCL clock only.
- R3: An address byte equal to 0x00 is acknowledged whatever own_addr holds. The byte 0x01 is treated as a mismatch unless own_addr[7:1] is zero.
- R4: On a mismatching address, SDA stays released. Further SCL clocks produce no wr_valid, no rd_req and no SDA pull until the next START.
- R5: Address bit 0 = 0 selects master-write and clears byte_index to 0. Each received byte (MSB first) appears on wr_data while wr_valid is high for one cycle, with its index on byte_index. byte_index then increments.
- R6: If wr_accept is 1 while wr_valid is high, SDA is pulled low for the following acknowledge clock. If wr_accept is 0, SDA stays released, which is a NAK.
- R7: Address bit 0 = 1 selects master-read without clearing byte_index. rd_req stays high with the current byte_index until rd_ack is seen. The rd_data byte is then driven MSB first and byte_index increments.
- R8: A high master acknowledge bit (NACK) after a read byte ends the transfer, with no further rd_req or SDA pull. A low bit (ACK) causes the next byte to be requested.
- R9: A START (SDA falling while SCL is high) restarts address reception from any state, including in the middle of a byte.
- R10: A STOP (SDA rising while SCL is high) returns the engine to idle. Later SCL clocks without a START are ignored.
- R11: sda_pull changes only while SCL is low, and scl_pull is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 8 | Target address in 8-bit form; bit 0 is ignored |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | SCL pull-down enable (never used) |
| sda_pull | output | 1 | SDA pull-down enable |
| rd_req | output | 1 | Request for the read byte at byte_index |
| rd_ack | input | 1 | User logic has placed the read byte on rd_data |
| rd_data | input | 8 | Byte to send to the master |
| wr_valid | output | 1 | One-cycle strobe: a written byte is on wr_data |
| wr_accept | input | 1 | Acknowledge (1) or refuse (0) the byte shown with wr_valid |
| wr_data | output | 8 | Byte received from the master |
| byte_index | output | 8 | Byte position within the current transfer |

## Verification
Bus events reach the engine about six system cycles after the line changes: two synchronizer flops, three filter samples and the level register. The SDA pull for an acknowledge or a data bit therefore settles within roughly ten cycles after an SCL fall, and the read handshake adds two more. The bench holds each SCL phase for at least twenty cycles. It samples the SDA line just before each SCL fall, well after any pull is due. wr_valid is a single-cycle strobe, so it is logged at every falling clock edge. The write-stream checks then compare the logged sequence once the bus transfer has ended.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_TX_WAIT,
    ST_TX_BIT,
    ST_TX_ACK,
    ST_RX_BIT,
    ST_RX_ACK
  } tgt_state_t;

  localparam int unsigned BYTE_W = 8;

  // Address selection: general call (whole byte zero) or upper seven bits equal
  function automatic logic addr_selects(input logic [BYTE_W-1:0] rx_byte,
                                        input logic [BYTE_W-1:0] own);
    logic gen_call;
    logic own_hit;
    gen_call = (rx_byte == '0);
    own_hit  = (rx_byte[BYTE_W-1:1] == own[BYTE_W-1:1]);
    return gen_call || own_hit;
  endfunction

  // Direction bit: 1 means the master reads from this target
  function automatic logic is_master_read(input logic [BYTE_W-1:0] rx_byte);
    return rx_byte[0];
  endfunction

endpackage

// File: rtl/i2ct_line_filter.sv
module i2ct_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q) begin
        level_q <= 1'b1;
      end else if (~|hist_q) begin
        level_q <= 1'b0;
      end
    end
  end

  assign level_o = level_q;

endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_prev_q;
  logic sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_lvl;
      sda_prev_q <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl && !scl_prev_q;
  assign scl_fall  = !scl_lvl && scl_prev_q;
  // both conditions need SCL high before and after the SDA edge
  assign start_evt = scl_lvl && scl_prev_q && sda_prev_q && !sda_lvl;
  assign stop_evt  = scl_lvl && scl_prev_q && !sda_prev_q && sda_lvl;

endmodule

// File: rtl/i2ct_target_fsm.sv
module i2ct_target_fsm
  import i2ct_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              rd_ack,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              wr_accept,
  output logic              sda_pull,
  output logic              rd_req,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IDX_W-1:0]  byte_index,
  output tgt_state_t        state_o,
  output logic              addr_miss
);

  localparam int unsigned CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  tgt_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              pull_q;
  logic              req_q;
  logic              dir_rd_q;
  logic              mnack_q;
  logic              byte_done;
  logic              addr_hit;

  assign byte_done = scl_fall && (cnt_q == FULL_CNT);
  assign addr_hit  = addr_selects(shreg_q, own_addr);
  assign addr_miss = (state_q == ST_ADDR) && byte_done && !addr_hit;
  assign wr_valid  = (state_q == ST_RX_BIT) && byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      shreg_q  <= '0;
      idx_q    <= '0;
      pull_q   <= 1'b0;
      req_q    <= 1'b0;
      dir_rd_q <= 1'b0;
      mnack_q  <= 1'b1;
    end else if (start_evt) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
      req_q   <= 1'b0;
    end else if (stop_evt) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
            cnt_q   <= cnt_q + 1'b1;
          end else if (byte_done) begin
            if (addr_hit) begin
              pull_q   <= 1'b1;
              dir_rd_q <= is_master_read(shreg_q);
              if (!is_master_read(shreg_q)) idx_q <= '0;
              state_q  <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            pull_q <= 1'b0;
            cnt_q  <= '0;
            if (dir_rd_q) begin
              req_q   <= 1'b1;
              state_q <= ST_TX_WAIT;
            end else begin
              state_q <= ST_RX_BIT;
            end
          end
        end
        ST_TX_WAIT: begin
          if (req_q && rd_ack) begin
            req_q   <= 1'b0;
            shreg_q <= rd_data;
            pull_q  <= !rd_data[BYTE_W-1];
            idx_q   <= idx_q + 1'b1;
            cnt_q   <= '0;
            state_q <= ST_TX_BIT;
          end
        end
        ST_TX_BIT: begin
          if (scl_fall) begin
            if (cnt_q == LAST_TX) begin
              pull_q  <= 1'b0;
              state_q <= ST_TX_ACK;
            end else begin
              pull_q  <= !shreg_q[BYTE_W-2];
              shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
              cnt_q   <= cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mnack_q <= sda_lvl;
          end else if (scl_fall) begin
            if (mnack_q) begin
              state_q <= ST_IDLE;
            end else begin
              req_q   <= 1'b1;
              state_q <= ST_TX_WAIT;
            end
          end
        end
        ST_RX_BIT: begin
          if (scl_rise) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
            cnt_q   <= cnt_q + 1'b1;
          end else if (byte_done) begin
            pull_q  <= wr_accept;
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            pull_q  <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_RX_BIT;
          end
        end
        default: begin
          pull_q <= 1'b0;
        end
      endcase
    end
  end

  assign sda_pull   = pull_q;
  assign rd_req     = req_q;
  assign wr_data    = shreg_q;
  assign byte_index = idx_q;
  assign state_o    = state_q;

endmodule

// File: rtl/i2c_indexed_target.sv
module i2c_indexed_target
  import i2ct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned IDX_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       own_addr,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             rd_req,
  input  logic             rd_ack,
  input  logic [7:0]       rd_data,
  output logic             wr_valid,
  input  logic             wr_accept,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] byte_index
);

  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] flt_lines;
  logic               scl_flt;
  logic               sda_flt;
  logic               ev_scl_rise;
  logic               ev_scl_fall;
  logic               ev_start;
  logic               ev_stop;
  logic               ev_addr_miss;
  tgt_state_t         fsm_state;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2ct_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_in(raw_lines[g]),
      .level_o(flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[0];
  assign sda_flt = flt_lines[1];

  i2ct_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_flt),
    .sda_lvl  (sda_flt),
    .scl_rise (ev_scl_rise),
    .scl_fall (ev_scl_fall),
    .start_evt(ev_start),
    .stop_evt (ev_stop)
  );

  i2ct_target_fsm #(
    .IDX_W(IDX_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .own_addr  (own_addr),
    .sda_lvl   (sda_flt),
    .scl_rise  (ev_scl_rise),
    .scl_fall  (ev_scl_fall),
    .start_evt (ev_start),
    .stop_evt  (ev_stop),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .wr_accept (wr_accept),
    .sda_pull  (sda_pull),
    .rd_req    (rd_req),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .byte_index(byte_index),
    .state_o   (fsm_state),
    .addr_miss (ev_addr_miss)
  );

  // no clock stretching: SCL is never held
  assign scl_pull = 1'b0;

endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
  import i2ct_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_flt,
  input logic             sda_pull,
  input logic             rd_req,
  input logic             rd_ack,
  input logic             wr_valid,
  input logic             wr_accept,
  input logic [IDX_W-1:0] byte_index,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             ev_addr_miss,
  input tgt_state_t       fsm_state
);

  // R11
  pull_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_flt);

  // R4
  miss_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_miss |=> (!sda_pull && fsm_state == ST_IDLE));

  // R9
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (fsm_state == ST_ADDR));

  // R10
  stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (fsm_state == ST_IDLE && !sda_pull));

  // R5
  write_index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (byte_index == IDX_W'($past(byte_index) + 1'b1)));

  // R6
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_accept) |=> sda_pull);

  // R6
  write_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_accept) |=> !sda_pull);

  // R7
  read_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req);

  // R7
  read_index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> (!rd_req && byte_index == IDX_W'($past(byte_index) + 1'b1)));

endmodule

bind i2c_indexed_target i2ct_checker #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_flt     (scl_flt),
  .sda_pull    (sda_pull),
  .rd_req      (rd_req),
  .rd_ack      (rd_ack),
  .wr_valid    (wr_valid),
  .wr_accept   (wr_accept),
  .byte_index  (byte_index),
  .ev_start    (ev_start),
  .ev_stop     (ev_stop),
  .ev_addr_miss(ev_addr_miss),
  .fsm_state   (fsm_state)
);

// File: tb/i2c_indexed_target_test.sv
module i2c_indexed_target_test;

  localparam int HP = 20;   // SCL half period in system cycles
  localparam int Q  = 4;    // data hold after SCL fall
  localparam logic [7:0] OWN = 8'h84;
  localparam int NVEC = 6;
  // {address byte, expected acknowledge}
  localparam logic [8:0] ADDR_VEC [NVEC] = '{
    {8'h84, 1'b1}, {8'h85, 1'b1}, {8'h00, 1'b1},
    {8'h01, 1'b0}, {8'h86, 1'b0}, {8'h04, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       scl_line, sda_line;
  logic       scl_pull, sda_pull, rd_req, rd_ack, wr_valid, wr_accept;
  logic [7:0] rd_data, wr_data, byte_index;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  logic [7:0] wr_d [32];
  logic [7:0] wr_i [32];
  logic [7:0] rd_i [32];
  int wr_n = 0;
  int rd_n = 0;

  always #2.5 clk = ~clk;

  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  i2c_indexed_target uut (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_accept(wr_accept), .wr_data(wr_data),
    .byte_index(byte_index)
  );

  function automatic logic exp_hit(input logic [7:0] a);
    return (a == 8'h00) || ((a | 8'h01) == (OWN | 8'h01));
  endfunction

  function automatic logic [7:0] rd_pattern(input logic [7:0] i);
    return i ^ 8'hA5;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // read responder: answers one cycle after the request
  initial begin
    rd_ack = 1'b0;
    rd_data = 8'h00;
    forever begin
      @(negedge clk);
      if (rd_req && !rd_ack) begin
        rd_data = rd_pattern(byte_index);
        rd_i[rd_n % 32] = byte_index;
        rd_n++;
        rd_ack = 1'b1;
      end else begin
        rd_ack = 1'b0;
      end
    end
  end

  // write logger and pull-timing monitor (R11)
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (wr_valid) begin
        wr_d[wr_n % 32] = wr_data;
        wr_i[wr_n % 32] = byte_index;
        wr_n++;
      end
      if (rst_n && ((sda_pull != prev && scl_line) || scl_pull)) viol++;
      prev = sda_pull;
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    tick(Q);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic bus_bit(input logic b, output logic line);
    sda_m = b; tick(HP);
    scl_m = 1'b1; tick(HP);
    line = sda_line;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic l;
    for (int k = 7; k >= 0; k--) bus_bit(v[k], l);
    bus_bit(1'b1, l);
    acked = !l;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] v);
    logic l;
    for (int k = 7; k >= 0; k--) begin
      bus_bit(1'b1, l);
      v[k] = l;
    end
    bus_bit(!master_ack, l);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (R8 flow) actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v;
    int base;
    wr_accept = 1'b1;
    tick(5);
    // R1: reset state
    check(sda_pull == 0 && scl_pull == 0 && rd_req == 0 && wr_valid == 0,
          "R1 outputs", {sda_pull, scl_pull, rd_req, wr_valid}, 0);
    rst_n = 1'b1;
    tick(10);
    check(byte_index == 0, "R1 index", byte_index, 0);

    // R2 R3: address table
    for (int n = 0; n < NVEC; n++) begin
      bus_start();
      send_byte(ADDR_VEC[n][8:1], a);
      check(a == ADDR_VEC[n][0] && a == exp_hit(ADDR_VEC[n][8:1]),
            (ADDR_VEC[n][8:1] == 8'h00) ? "R3 general call" : "R2 address",
            a, ADDR_VEC[n][0]);
      if (a && ADDR_VEC[n][1]) recv_byte(1'b0, v);
      bus_stop();
    end

    // R5 R6: write stream with an accepted and a refused byte
    base = wr_n;
    bus_start();
    send_byte(OWN, a);
    send_byte(8'h3C, a); check(a == 1, "R6 ack byte0", a, 1);
    send_byte(8'h81, a);
    send_byte(8'hFF, a); check(a == 1, "R6 ack byte2", a, 1);
    wr_accept = 1'b0;
    send_byte(8'h55, a); check(a == 0, "R6 nak when refused", a, 0);
    wr_accept = 1'b1;
    bus_stop();
    check(wr_n - base == 4, "R5 byte count", wr_n - base, 4);
    check(wr_d[base % 32] == 8'h3C && wr_d[(base + 1) % 32] == 8'h81,
          "R5 data msb first", wr_d[(base + 1) % 32], 8'h81);
    check(wr_i[base % 32] == 0 && wr_i[(base + 3) % 32] == 3,
          "R5 index 0..3", wr_i[(base + 3) % 32], 3);

    // R7 R8: read continues at index 4
    base = rd_n;
    bus_start();
    send_byte(OWN | 8'h01, a);
    recv_byte(1'b1, v);
    check(v == rd_pattern(8'd4), "R7 data at index 4", v, rd_pattern(8'd4));
    recv_byte(1'b0, v);
    check(v == rd_pattern(8'd5), "R8 next byte after ack", v, rd_pattern(8'd5));
    check(rd_i[base % 32] == 4, "R7 index not cleared", rd_i[base % 32], 4);
    // after NACK: clock another byte, target must stay silent
    recv_byte(1'b0, v);
    check(v == 8'hFF && rd_n - base == 2, "R8 silent after nack", v, 8'hFF);
    bus_stop();

    // R9: repeated start mid-byte, then general call write
    base = wr_n;
    bus_start();
    send_byte(OWN, a);
    bus_bit(1'b1, a); bus_bit(1'b0, a); bus_bit(1'b1, a);
    bus_start();
    send_byte(8'h00, a); check(a == 1, "R9 address after restart", a, 1);
    send_byte(8'h22, a);
    bus_stop();
    check(wr_n - base == 1 && wr_d[base % 32] == 8'h22 && wr_i[base % 32] == 0,
          "R9 clean byte after restart", wr_d[base % 32], 8'h22);

    // R4: mismatch ignores following clocks
    base = wr_n;
    bus_start();
    send_byte(8'h86, a);
    send_byte(8'h77, a); check(a == 0, "R4 no ack after miss", a, 0);
    bus_stop();
    check(wr_n == base, "R4 no write strobe", wr_n - base, 0);

    // R10: clocks after STOP are ignored
    base = wr_n;
    bus_start();
    send_byte(OWN, a);
    bus_stop();
    scl_m = 1'b0; tick(Q);
    send_byte(OWN, a); check(a == 0, "R10 idle after stop", a, 0);
    send_byte(8'h00, a);
    scl_m = 1'b1; sda_m = 1'b1; tick(HP);
    check(wr_n == base, "R10 no strobe after stop", wr_n - base, 0);

    // R11: pull timing
    check(viol == 0, "R11 pull only while scl low", viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule